// File: doc/BRIEF.md
# Attribute-Typed Configuration Register Bank

This block is a small bank of configuration and status registers for a graphics and memory hub. Software reaches it over a plain synchronous bus with a word address, a 32-bit write data word, a write strobe, four byte enables, a read strobe and a registered read data word. Each register follows its own access rule: plain read/write, write-one-to-clear with hardware set, write-once after power-up, read-only, and one address where a read and a write reach two separate registers.

The bank holds a device-mode register. Its mode bit picks external-card operation or internal-graphics operation and drives two active-device outputs that are never both high. Its lock bit freezes the choice until the next reset. It also holds a memory configuration register whose frequency bit selects the faster memory clock. A group of eight display timing registers can be write-protected by one bit of a protect register. Status bits are set by hardware event pulses. A second register at the status-level address returns sampled hardware levels on a read, and a write to that address lands in a command register that drives an output.

The bus has no stall path. Every access completes in the cycle it is presented, so the bank never applies back-pressure and needs no valid/ready handshake. Read data is returned one cycle after the read strobe.

Top module: `cfg_regbank`

## Requirements
- R1: After reset every writable register reads 0. The mode bit is 0, so ext_port_active=1 and int_gfx_active=0. mem_fast=0, cmd_out=0 and rdata=0.
- R2: When ren is high at a rising edge, rdata shows the addressed register's value from before that edge. rdata holds its value while ren is low.
- R3: A write changes only the bits in byte lanes whose be bit is 1 (lane n is wdata[8n+7:8n]). A write with be=0 changes nothing.
- R4: The mode register is at address 0x00. Bit 0 is the mode (1 = internal graphics) and bit 2 is the lock. Writes through lane 0 update both bits while the lock is 0, and the lock may be set in the same write. Once the lock reads 1, writes leave both bits unchanged. int_gfx_active equals the mode bit and ext_port_active is its inverse, so the two are never both 1.
- R5: The status register is at 0x02, bits [7:0]. A rising edge with hw_event[i]=1 sets bit i. A lane-0 write clears the bits written as 1 and keeps the bits written as 0. If a set and a clear hit the same bit in the same cycle, the bit ends up 1.
- R6: The write-once register is at 0x04, 32 bits. The first write with any byte enable high loads the enabled lanes. Every later write is ignored until reset.
- R7: The identity register at 0x03 always reads the parameter DEV_ID (default 0xC0DE1234). Writes to it have no effect.
- R8: At address 0x05, a write loads lane 0 into the command register, which drives cmd_out[7:0]. A read returns the hw_level input sampled at the read edge in bits [7:0]. A read never changes cmd_out.
- R9: The memory configuration register is at 0x01, bits [7:0], read/write. Bit 2 drives mem_fast (0 = 100 MHz, 1 = 133 MHz).
- R10: The protect register is at 0x11, bits [7:0], and is always writable. The timing registers 0..7 are at 0x18..0x1F, bits [7:0]. While protect bit 7 is 1, writes to the timing registers are ignored. While it is 0, they are accepted.
- R11: Reading any address not listed above returns 0. Writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe |
| be | input | 4 | Byte enables for writes |
| ren | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| hw_event | input | 8 | Status set pulses |
| hw_level | input | 8 | Levels returned by reads of 0x05 |
| int_gfx_active | output | 1 | Internal graphics device active |
| ext_port_active | output | 1 | External port device active |
| mem_fast | output | 1 | Faster memory clock selected |
| cmd_out | output | 8 | Command register value |

## Verification
Each write takes effect at the edge that samples wen, so its effect is visible one cycle later. Register-driven outputs such as int_gfx_active, mem_fast and cmd_out are therefore sampled at the falling edge after the write cycle. A read issued in the next cycle returns the new value in rdata one edge after ren. A hardware event pulse is captured at its edge, so the status read that follows already shows it. The bench drives each access for exactly one cycle from the falling edge and samples rdata and the outputs at the following falling edge. No value is read at the edge where it changes.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;
  localparam int A_MODE   = 'h00;
  localparam int A_MEMCFG = 'h01;
  localparam int A_STAT   = 'h02;
  localparam int A_IDENT  = 'h03;
  localparam int A_ONCE   = 'h04;
  localparam int A_DUAL   = 'h05;
  localparam int A_PROT   = 'h11;
  localparam int A_TIM0   = 'h18;
  localparam int PROT_BIT = 7;
  localparam int MODE_BIT = 0;
  localparam int LOCK_BIT = 2;
  localparam int FAST_BIT = 2;
endpackage

// File: rtl/cfgrb_mode.sv
module cfgrb_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wmode,
  input  logic wlock,
  output logic mode_q,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr && !lock_q) begin
      mode_q <= wmode;
      lock_q <= wlock;
    end
  end

  // R4: once locked, the mode and the lock never move
  a_r4_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(mode_q)));
endmodule

// File: rtl/cfgrb_status.sv
module cfgrb_status #(
  parameter int NSTAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic [NSTAT-1:0] clr_bits,
  input  logic [NSTAT-1:0] set,
  output logic [NSTAT-1:0] stat_q
);
  logic [NSTAT-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | set;
  end

  // R5: an event always leaves its bit set, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((stat_q & $past(set)) == $past(set)));
endmodule

// File: rtl/cfgrb_timing.sv
module cfgrb_timing #(
  parameter int NTIM  = 8,
  parameter int TW    = 8,
  localparam int IDX_W = (NTIM > 1) ? $clog2(NTIM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic [TW-1:0]        wdat,
  input  logic                 prot,
  output logic [NTIM-1:0][TW-1:0] tim_q
);
  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n) tim_q[g] <= '0;
      else if (wr && !prot && (idx == IDX_W'(g))) tim_q[g] <= wdat;
    end
  end

  // R10: a protected group does not change on a write
  a_r10_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && prot) |=> $stable(tim_q));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgrb_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter int          DATA_W = 32,
  parameter int          NSTAT  = 8,
  parameter int          NTIM   = 8,
  parameter int          LVL_W  = 8,
  parameter logic [31:0] DEV_ID = 32'hC0DE_1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wen,
  input  logic [DATA_W/8-1:0] be,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSTAT-1:0]  hw_event,
  input  logic [LVL_W-1:0]  hw_level,
  output logic              int_gfx_active,
  output logic              ext_port_active,
  output logic              mem_fast,
  output logic [7:0]        cmd_out
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (NTIM > 1) ? $clog2(NTIM) : 1;

  logic [DATA_W-1:0] bmask;
  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign bmask[8*g +: 8] = {8{be[g]}};
  end

  logic hit_mode, hit_mcfg, hit_stat, hit_id, hit_once, hit_dual, hit_prot, hit_tim;
  assign hit_mode = (addr == ADDR_W'(A_MODE));
  assign hit_mcfg = (addr == ADDR_W'(A_MEMCFG));
  assign hit_stat = (addr == ADDR_W'(A_STAT));
  assign hit_id   = (addr == ADDR_W'(A_IDENT));
  assign hit_once = (addr == ADDR_W'(A_ONCE));
  assign hit_dual = (addr == ADDR_W'(A_DUAL));
  assign hit_prot = (addr == ADDR_W'(A_PROT));
  assign hit_tim  = (addr >= ADDR_W'(A_TIM0)) && (addr < ADDR_W'(A_TIM0 + NTIM));

  logic [IDX_W-1:0] tim_idx;
  assign tim_idx = IDX_W'(addr - ADDR_W'(A_TIM0));

  // Mode / lock
  logic mode_q, lock_q;
  cfgrb_mode u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr(wen && hit_mode && be[0]),
    .wmode(wdata[MODE_BIT]), .wlock(wdata[LOCK_BIT]),
    .mode_q(mode_q), .lock_q(lock_q)
  );
  assign int_gfx_active  = mode_q;
  assign ext_port_active = ~mode_q;

  // Status, write-one-to-clear
  logic [NSTAT-1:0] stat_q;
  cfgrb_status #(.NSTAT(NSTAT)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .clr_wr(wen && hit_stat),
    .clr_bits(wdata[NSTAT-1:0] & bmask[NSTAT-1:0]),
    .set(hw_event), .stat_q(stat_q)
  );

  // Display timing group with protection
  logic [7:0] prot_q;
  logic [NTIM-1:0][7:0] tim_q;
  cfgrb_timing #(.NTIM(NTIM), .TW(8)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .wr(wen && hit_tim && be[0]),
    .idx(tim_idx), .wdat(wdata[7:0]),
    .prot(prot_q[PROT_BIT]), .tim_q(tim_q)
  );

  // Plain registers
  logic [7:0]        mcfg_q;
  logic [7:0]        cmd_q;
  logic [DATA_W-1:0] once_q;
  logic              once_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcfg_q    <= '0;
      prot_q    <= '0;
      cmd_q     <= '0;
      once_q    <= '0;
      once_done <= 1'b0;
    end else if (wen) begin
      if (hit_mcfg && be[0]) mcfg_q <= wdata[7:0];
      if (hit_prot && be[0]) prot_q <= wdata[7:0];
      if (hit_dual && be[0]) cmd_q  <= wdata[7:0];
      if (hit_once && !once_done && (be != '0)) begin
        once_q    <= (once_q & ~bmask) | (wdata & bmask);
        once_done <= 1'b1;
      end
    end
  end

  assign mem_fast = mcfg_q[FAST_BIT];
  assign cmd_out  = cmd_q;

  // Read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_mode) begin
      rd_mux[MODE_BIT] = mode_q;
      rd_mux[LOCK_BIT] = lock_q;
    end
    else if (hit_mcfg) rd_mux[7:0]       = mcfg_q;
    else if (hit_stat) rd_mux[NSTAT-1:0] = stat_q;
    else if (hit_id)   rd_mux            = DATA_W'(DEV_ID);
    else if (hit_once) rd_mux            = once_q;
    else if (hit_dual) rd_mux[LVL_W-1:0] = hw_level;
    else if (hit_prot) rd_mux[7:0]       = prot_q;
    else if (hit_tim)  rd_mux[7:0]       = tim_q[tim_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (ren) rdata <= rd_mux;
  end

  // R6: write-once content is frozen after the first write
  a_r6_once_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(once_done) && once_done) |-> $stable(once_q));

  // R8: a read alone never touches the command register
  a_r8_read_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && !wen) |=> $stable(cmd_out));

  // R2: read data holds while no read is issued
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata));
endmodule

// File: tb/cfg_regbank_bench.sv
`timescale 1ns/1ps
module cfg_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic [3:0]  be = '0;
  logic        ren = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  hw_event = '0;
  logic [7:0]  hw_level = '0;
  logic        int_gfx_active, ext_port_active, mem_fast;
  logic [7:0]  cmd_out;

  localparam logic [31:0] ID = 32'hC0DE_1234;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cfg_regbank u_cfg_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen),
    .be(be), .ren(ren), .rdata(rdata), .hw_event(hw_event),
    .hw_level(hw_level), .int_gfx_active(int_gfx_active),
    .ext_port_active(ext_port_active), .mem_fast(mem_fast), .cmd_out(cmd_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; ren = 1'b1;
    @(negedge clk);
    ren = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    hw_event = ev;
    @(negedge clk);
    hw_event = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", rdata, 0);
    chk("R1 ext_port_active", {31'b0, ext_port_active}, 1);
    chk("R1 int_gfx_active", {31'b0, int_gfx_active}, 0);
    chk("R1 mem_fast", {31'b0, mem_fast}, 0);
    chk("R1 cmd_out", {24'b0, cmd_out}, 0);
    rd(6'h00, d); chk("R1 mode", d, 0);
    rd(6'h01, d); chk("R1 memcfg", d, 0);
    rd(6'h02, d); chk("R1 status", d, 0);
    rd(6'h04, d); chk("R1 once", d, 0);
    rd(6'h11, d); chk("R1 protect", d, 0);
    rd(6'h1C, d); chk("R1 timing4", d, 0);
  endtask

  task automatic t_memcfg();
    logic [31:0] d;
    wr(6'h01, 32'h0000_0004, 4'h1);
    chk("R9 mem_fast set", {31'b0, mem_fast}, 1);
    rd(6'h01, d); chk("R9 memcfg read", d, 32'h04);
    wr(6'h01, 32'hFFFF_FFFF, 4'h0);
    rd(6'h01, d); chk("R3 be=0 no change", d, 32'h04);
    wr(6'h01, 32'h0000_FF00, 4'hE);
    rd(6'h01, d); chk("R3 lane0 off", d, 32'h04);
    // R2: rdata holds while ren is low
    @(negedge clk); @(negedge clk);
    chk("R2 hold", rdata, 32'h04);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse(8'hA5);
    rd(6'h02, d); chk("R5 set by events", d, 32'hA5);
    wr(6'h02, 32'h05, 4'h1);
    rd(6'h02, d); chk("R5 write1 clears", d, 32'hA0);
    wr(6'h02, 32'h00, 4'h1);
    rd(6'h02, d); chk("R5 write0 keeps", d, 32'hA0);
    @(negedge clk);
    addr = 6'h02; wdata = 32'h80; be = 4'h1; wen = 1'b1; hw_event = 8'h80;
    @(negedge clk);
    wen = 1'b0; be = '0; hw_event = '0;
    rd(6'h02, d); chk("R5 set wins", d, 32'hA0);
    wr(6'h02, 32'hFF, 4'h0);
    rd(6'h02, d); chk("R3 status be=0", d, 32'hA0);
    wr(6'h02, 32'hFF, 4'h1);
    rd(6'h02, d); chk("R5 clear all", d, 32'h00);
  endtask

  task automatic t_once();
    logic [31:0] d;
    wr(6'h04, 32'h1234_5678, 4'h3);
    rd(6'h04, d); chk("R6 first write lanes", d, 32'h0000_5678);
    wr(6'h04, 32'hFFFF_FFFF, 4'hF);
    rd(6'h04, d); chk("R6 second write ignored", d, 32'h0000_5678);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    wr(6'h03, 32'h0, 4'hF);
    rd(6'h03, d); chk("R7 ident", d, ID);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    hw_level = 8'h3C;
    wr(6'h05, 32'h5A, 4'h1);
    chk("R8 cmd_out", {24'b0, cmd_out}, 32'h5A);
    rd(6'h05, d); chk("R8 read level", d, 32'h3C);
    chk("R8 cmd after read", {24'b0, cmd_out}, 32'h5A);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) wr(6'(6'h18 + i), 32'(i * 17 + 1), 4'h1);
    for (int i = 0; i < 8; i++) begin
      rd(6'(6'h18 + i), d); chk("R10 timing readback", d, 32'(i * 17 + 1));
    end
    wr(6'h11, 32'h80, 4'h1);
    rd(6'h11, d); chk("R10 protect read", d, 32'h80);
    wr(6'h1B, 32'hEE, 4'h1);
    rd(6'h1B, d); chk("R10 protected ignored", d, 32'h34);
    wr(6'h11, 32'h00, 4'h1);
    wr(6'h1B, 32'hEE, 4'h1);
    rd(6'h1B, d); chk("R10 unprotected write", d, 32'hEE);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(6'h3F, 32'hFFFF_FFFF, 4'hF);
    wr(6'h06, 32'hFFFF_FFFF, 4'hF);
    rd(6'h3F, d); chk("R11 unmapped read 3F", d, 0);
    rd(6'h06, d); chk("R11 unmapped read 06", d, 0);
    rd(6'h01, d); chk("R11 memcfg untouched", d, 32'h04);
    chk("R11 cmd untouched", {24'b0, cmd_out}, 32'h5A);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(6'h00, 32'h1, 4'h0);
    chk("R3 mode be=0", {31'b0, int_gfx_active}, 0);
    wr(6'h00, 32'h1, 4'h1);
    chk("R4 int active", {30'b0, int_gfx_active, ext_port_active}, 32'b10);
    wr(6'h00, 32'h0, 4'h1);
    chk("R4 unlocked back", {30'b0, int_gfx_active, ext_port_active}, 32'b01);
    wr(6'h00, 32'h5, 4'h1);
    rd(6'h00, d); chk("R4 mode+lock", d, 32'h5);
    wr(6'h00, 32'h0, 4'h1);
    rd(6'h00, d); chk("R4 locked ignored", d, 32'h5);
    chk("R4 exclusive", {30'b0, int_gfx_active, ext_port_active}, 32'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_memcfg();
    t_status();
    t_once();
    t_ident();
    t_dual();
    t_timing();
    t_unmapped();
    t_mode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule